// File: doc/BRIEF.md
# Twisted-Pair Receive Squelch Controller

This block decides when a 10 Mbit/s twisted-pair receiver should stop ignoring the line and treat the activity it sees as the start of a packet. It runs on a fixed sampling clock and reads two comparator flags. `pos_flag` means the line is above the positive squelch threshold. `neg_flag` means the line is below the negative threshold. The analog comparators, threshold trimming, equalization and link-pulse checks all live outside the block, and the block drives no link-status output.

The block leaves squelch after it sees three threshold crossings that alternate in polarity and fit inside a bounded time window. At that point it raises carrier sense. It returns to squelch, and drops carrier sense, when it sees the start-of-idle pattern: the positive flag held for a run of samples with no negative excursion. The window limits and the start-of-idle length are parameters. At a 100 MHz sampling rate the defaults (5 to 25 cycles, 16 cycles) match a 50 to 250 ns window.

Top module: `squelch_ctl`

## Requirements
- R1: An exceedance is the rising edge of one comparator flag (the flag is 1 now and was 0 at the previous sample) while the other flag is 0. A positive exceedance comes from `pos_flag` and a negative one from `neg_flag`. While squelched, only a third exceedance that alternates in polarity with the previous two can make the block unsquelch.
- R2: The span is the number of sampling edges from the edge that samples the first exceedance to the edge that samples the third, and it must lie between MIN_SPAN (5) and MAX_SPAN (25) inclusive. If a third alternating exceedance comes with a span below MIN_SPAN, the block stays squelched and that exceedance becomes the first of a new sequence.
- R3: A partial sequence whose first exceedance is more than MAX_SPAN edges old is dropped, so a later exceedance starts a new sequence and cannot complete the old one.
- R4: An exceedance of the same polarity as the one before it restarts the sequence at a count of one, taking the new exceedance as its first.
- R5: While unsquelched, SOI_CYCLES (16) consecutive samples with `pos_flag`=1 and `neg_flag`=0 return the block to squelch, with `crs` low after the edge that takes the last of those samples. Any other sample restarts this run.
- R6: A sample with both flags at 1 is invalid. It counts as no exceedance, clears any partial sequence, and cannot cause the block to unsquelch.
- R7: While reset is asserted, and right after it is released, `squelch`=1, `crs`=0, and no partial sequence or idle run is held.
- R8: `crs` goes high and `squelch` goes low on the clock edge that samples the qualifying third exceedance. `squelch` is always the inverse of `crs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_flag | input | 1 | Line is above the positive squelch threshold |
| neg_flag | input | 1 | Line is below the negative squelch threshold |
| squelch | output | 1 | 1 while the receiver is squelched |
| crs | output | 1 | Carrier sense, high from start of packet until start of idle |

## Verification
If the internal sequence count or span timer goes wrong, `crs` rises one edge too early or too late, or fails to rise, on the very edge that samples a third crossing. The bench places the third crossing exactly at spans 4, 5, 25 and 26, so an off-by-one error shows up on that edge. If the idle run counter goes wrong, `crs` falls an edge early or late at the end of a 16-sample positive hold, or in a hold that a negative excursion interrupted. A reference model compares `crs` and `squelch` on every cycle, so a wrong state shows within one cycle of the input that exposes it.

// File: rtl/squelch_ctl.sv
module squelch_ctl #(
  parameter int MIN_SPAN   = 5,
  parameter int MAX_SPAN   = 25,
  parameter int SOI_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_flag,
  input  logic neg_flag,
  output logic squelch,
  output logic crs
);
  localparam int TW = $clog2(MAX_SPAN + 2);
  localparam int SW = $clog2(SOI_CYCLES + 1);
  localparam logic [TW-1:0] SPAN_LO = TW'(MIN_SPAN);
  localparam logic [TW-1:0] SPAN_HI = TW'(MAX_SPAN);
  localparam logic [SW-1:0] SOI_END = SW'(SOI_CYCLES - 1);

  logic          pos_q, neg_q, active, last_pol;
  logic [1:0]    seq_cnt;
  logic [TW-1:0] span;
  logic [SW-1:0] soi_run;

  wire clash    = pos_flag & neg_flag;
  wire rise_p   = pos_flag & ~pos_q & ~neg_flag;
  wire rise_n   = neg_flag & ~neg_q & ~pos_flag;
  wire hit      = rise_p | rise_n;
  wire stale    = (seq_cnt != 2'd0) && (span > SPAN_HI);
  wire [1:0] live_cnt = stale ? 2'd0 : seq_cnt;
  wire alt      = (live_cnt != 2'd0) && (rise_p != last_pol);
  wire in_win   = (span >= SPAN_LO) && (span <= SPAN_HI);
  wire third_ok = hit && alt && (live_cnt == 2'd2) && in_win;
  wire soi_hold = pos_flag & ~neg_flag;
  wire soi_done = soi_hold && (soi_run == SOI_END);

  assign crs     = active;
  assign squelch = ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= 1'b0;
      neg_q    <= 1'b0;
      active   <= 1'b0;
      last_pol <= 1'b0;
      seq_cnt  <= 2'd0;
      span     <= '0;
      soi_run  <= '0;
    end else begin
      pos_q <= pos_flag;
      neg_q <= neg_flag;
      if (active) begin
        seq_cnt <= 2'd0;
        span    <= '0;
        if (soi_done) begin
          active  <= 1'b0;
          soi_run <= '0;
        end else if (soi_hold) begin
          soi_run <= soi_run + 1'b1;
        end else begin
          soi_run <= '0;
        end
      end else begin
        soi_run <= '0;
        if (seq_cnt != 2'd0 && span <= SPAN_HI) span <= span + 1'b1;
        if (clash) begin
          seq_cnt <= 2'd0;
        end else if (hit) begin
          last_pol <= rise_p;
          if (third_ok) begin
            active  <= 1'b1;
            seq_cnt <= 2'd0;
          end else if (alt && live_cnt == 2'd1) begin
            seq_cnt <= 2'd2;
          end else begin
            seq_cnt <= 2'd1;
            span    <= TW'(1);
          end
        end else if (stale) begin
          seq_cnt <= 2'd0;
        end
      end
    end
  end
endmodule

module squelch_ctl_chk #(
  parameter int MIN_SPAN = 5,
  parameter int MAX_SPAN = 25,
  parameter int TW       = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pos_flag,
  input logic          neg_flag,
  input logic          squelch,
  input logic          crs,
  input logic [1:0]    seq_cnt,
  input logic [TW-1:0] span
);
  assert_rise_single_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crs) |-> ($past(pos_flag) != $past(neg_flag)));

  assert_span_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crs) |-> (int'($past(span)) >= MIN_SPAN && int'($past(span)) <= MAX_SPAN));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_cnt != 2'd3);

  assert_soi_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crs) |-> $past(pos_flag && !neg_flag));

  assert_clash_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_flag && neg_flag && squelch) |=> squelch);

  always @(negedge clk) begin
    if (!rst_n) assert_reset_state_R7: assert (!crs && squelch && seq_cnt == 2'd0);
  end
endmodule

bind squelch_ctl squelch_ctl_chk #(.MIN_SPAN(MIN_SPAN), .MAX_SPAN(MAX_SPAN), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pos_flag(pos_flag), .neg_flag(neg_flag),
  .squelch(squelch), .crs(crs), .seq_cnt(seq_cnt), .span(span)
);

// File: tb/squelch_ctl_test.sv
module squelch_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0, pos_flag = 1'b0, neg_flag = 1'b0;
  wire  squelch, crs;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  int cyc = 0, m_cnt = 0, m_t0 = 0, m_soi = 0;
  bit m_act = 1'b0, m_pol = 1'b0, m_pd = 1'b0, m_nd = 1'b0;

  always #4 clk = ~clk;

  squelch_ctl uut (.clk(clk), .rst_n(rst_n), .pos_flag(pos_flag), .neg_flag(neg_flag),
                   .squelch(squelch), .crs(crs));

  function void model_step(bit p, bit n);
    bit rp, rn, pol;
    cyc++;
    rp = p && !m_pd && !n;
    rn = n && !m_nd && !p;
    m_pd = p;
    m_nd = n;
    if (m_act) begin
      if (p && !n) m_soi++; else m_soi = 0;
      if (m_soi == 16) begin m_act = 0; m_soi = 0; m_cnt = 0; end
    end else begin
      if (m_cnt > 0 && cyc - m_t0 > 25) m_cnt = 0;
      if (p && n) m_cnt = 0;
      else if (rp || rn) begin
        pol = rp;
        if (m_cnt == 0 || pol == m_pol) begin m_cnt = 1; m_t0 = cyc; end
        else if (m_cnt == 1) m_cnt = 2;
        else if (cyc - m_t0 >= 5 && cyc - m_t0 <= 25) begin m_act = 1; m_cnt = 0; m_soi = 0; end
        else begin m_cnt = 1; m_t0 = cyc; end
        m_pol = pol;
      end
    end
  endfunction

  task automatic expect_crs(bit exp, string tag);
    checks++;
    if (crs !== exp || squelch !== !exp) begin
      fails++;
      $display("FAIL %s: crs=%0b squelch=%0b expected crs=%0b squelch=%0b", tag, crs, squelch, exp, !exp);
    end
  endtask

  task automatic tick(bit p, bit n);
    pos_flag = p;
    neg_flag = n;
    model_step(p, n);
    @(negedge clk);
    expect_crs(m_act, "R1/R8 per-cycle model");
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) tick(0, 0);
  endtask

  task automatic seq3(bit fp, int g1, int g2);
    tick(fp, !fp);
    idle(g1 - 1);
    tick(!fp, fp);
    idle(g2 - 1);
    tick(fp, !fp);
  endtask

  task automatic soi_plain();
    idle(2);
    for (int i = 0; i < 15; i++) tick(1, 0);
    expect_crs(1, "R5 one sample short of idle");
    tick(1, 0);
    expect_crs(0, "R5 idle detected");
    idle(3);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17C0DE));
    repeat (3) @(negedge clk);
    expect_crs(0, "R7 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    cyc = 1;
    expect_crs(0, "R7 after release");

    seq3(1, 2, 3);
    expect_crs(1, "R2 span 5 unsquelch, R8 same edge");
    idle(2);
    for (int i = 0; i < 10; i++) tick(1, 0);
    tick(0, 1);
    for (int i = 0; i < 15; i++) tick(1, 0);
    expect_crs(1, "R5 negative sample restarts idle run");
    tick(1, 0);
    expect_crs(0, "R5 idle after interrupted hold");
    idle(3);

    seq3(0, 12, 13);
    expect_crs(1, "R2 span 25 unsquelch");
    soi_plain();

    seq3(1, 2, 2);
    expect_crs(0, "R2 span 4 too fast");
    idle(2);
    tick(0, 1);
    idle(2);
    tick(1, 0);
    expect_crs(1, "R2 fast third restarts sequence");
    soi_plain();

    seq3(1, 13, 13);
    expect_crs(0, "R3 span 26 too slow");
    idle(30);
    tick(1, 0);
    idle(30);
    tick(0, 1);
    idle(2);
    tick(1, 0);
    expect_crs(0, "R3 expired first exceedance dropped");
    idle(30);

    tick(1, 0); idle(2); tick(0, 1); idle(2); tick(0, 1);
    expect_crs(0, "R4 repeat negative");
    idle(3); tick(1, 0);
    expect_crs(0, "R4 sequence restarted at one");
    idle(3); tick(0, 1);
    expect_crs(1, "R4 restarted sequence completes");
    soi_plain();

    tick(1, 0); idle(2); tick(0, 1); idle(1); tick(1, 1); tick(0, 0); tick(1, 0);
    expect_crs(0, "R6 clash cleared sequence");
    tick(0, 0); tick(0, 1); idle(2); tick(1, 0);
    expect_crs(1, "R6 fresh sequence after clash");
    soi_plain();

    for (int s = 0; s < 4000; s++) begin
      int r;
      r = $urandom % 10;
      if (r < 4) begin
        bit pol;
        pol = $urandom % 2;
        for (int w = 0; w <= int'($urandom % 2); w++) tick(pol, !pol);
        idle(1 + $urandom % 8);
      end else if (r == 4) begin
        tick(1, 1);
      end else if (r == 5) begin
        for (int h = 0; h < 10 + int'($urandom % 11); h++) tick(1, 0);
      end else begin
        idle(1 + $urandom % 6);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule